// File: doc/BRIEF.md
# Program-Counter Break Comparator

This block watches every cycle of a CPU bus and raises a break condition when a cycle matches one of two programmed breakpoints. Each channel holds a 24-bit break address and an 8-bit control byte. A bus cycle matches a channel when four things are all true. The address agrees with the stored address on the bits that take part in the comparison, since the control byte can exclude up to four low-order bits. The bus master is allowed. The access type is the selected one. The cycle is valid.

A match sets a sticky flag in the channel's control byte. If the channel's enable bit is set, the flag drives an interrupt request. The requests of the two channels are merged into one line. Software programs and inspects the channels through a byte-wide register port.

The flag is never cleared by hardware. Software clears it by reading it back as 1 and then writing 0 to it. A synchronous standby input returns both control bytes to zero. The break addresses are left as they are.

Top module: `pc_break_unit`

## Requirements
- R1: After reset, both control registers read 0x00 and `irq` is 0.
- R2: The register port maps `reg_addr` as {channel, slot}. Channel A uses index 0 and channel B uses index 1. Slots 0, 1 and 2 hold break-address bits [7:0], [15:8] and [23:16], and slot 3 is the control byte. A write takes effect at the clock edge, and a read returns the selected register in the same cycle.
- R3: The control byte holds these fields: bit 7 match flag, bit 6 transfer-controller enable, bits 5:3 mask code, bits 2:1 condition code, bit 0 interrupt enable. With mask code 0, a cycle matches only when all 24 address bits are equal.
- R4: Mask code n from 0 to 4 excludes address bits [n-1:0] from the comparison. Codes 5, 6 and 7 behave like code 4.
- R5: With bit 6 at 0, only cycles with `bus_dma`=0 (CPU owns the bus) can match. With bit 6 at 1, cycles with `bus_dma`=1 can also match.
- R6: The condition code selects the access type. 00 matches instruction fetch (`bus_fetch`=1). 01 matches a data read (`bus_fetch`=0, `bus_write`=0). 10 matches a data write (`bus_fetch`=0, `bus_write`=1). 11 matches any data access (`bus_fetch`=0).
- R7: A matching cycle sets the flag at the following clock edge, so a read in the next cycle shows it. The flag then stays set through later cycles that do not match.
- R8: Writing 0 to bit 7 clears the flag only when the previous access to that control byte was a read that returned the flag as 1. Any write to the control byte uses up that armed state. Writing 1 to bit 7 never changes the flag.
- R9: If a valid clear write and a matching bus cycle happen in the same cycle, the flag stays set.
- R10: `irq` is 1 exactly when at least one channel has both its flag and its interrupt enable set.
- R11: A cycle with `standby`=1 clears both control bytes, including the flags, at the next edge. The break addresses are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Synchronous clear of both control bytes |
| reg_addr | input | 3 | Register select {channel, slot} |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (same cycle) |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 24 | Bus cycle address |
| bus_dma | input | 1 | 1 when the transfer controller owns the bus |
| bus_fetch | input | 1 | 1 for an instruction fetch |
| bus_write | input | 1 | 1 for a data write |
| irq | output | 1 | Merged break interrupt request |

## Verification
A wrong comparator mask or a wrong master or type qualifier shows up as a flag value in the control byte, one cycle after the bus cycle. A lost or missing arm state shows up as a flag that survives, or disappears after, the next control write. A read of that control byte one cycle later exposes it. A corrupted enable or flag reaches `irq` in the same cycle the register changes. A standby that misses a register shows in the first read after it.

// File: rtl/pcb_pkg.sv
// Shared types for the program-counter break comparator.
// Assumes an 8-bit control byte; field order is fixed by the register decode.
package pcb_pkg;

    typedef enum logic [1:0] {
        COND_FETCH = 2'b00,
        COND_RD    = 2'b01,
        COND_WR    = 2'b10,
        COND_RW    = 2'b11
    } cond_e;

    typedef struct packed {
        logic       flag;    // bit 7: sticky match flag
        logic       dma_ok;  // bit 6: allow transfer-controller cycles
        logic [2:0] mask;    // bits 5:3: low address bits to ignore
        logic [1:0] cond;    // bits 2:1: access type
        logic       ie;      // bit 0: interrupt enable
    } ctrl_t;

endpackage

// File: rtl/pcb_addr_cmp.sv
// Combinational match detector for one channel: masked address compare,
// bus-master qualification and access-type qualification.
// Assumes mask codes above MASK_MAX saturate to MASK_MAX.
module pcb_addr_cmp #(
    parameter int ADDR_W   = 24,
    parameter int MASK_MAX = 4
) (
    input  logic [ADDR_W-1:0] bar,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        mask_code,
    input  logic [1:0]        cond,
    input  logic              dma_ok,
    input  logic              bus_valid,
    input  logic              bus_dma,
    input  logic              bus_fetch,
    input  logic              bus_write,
    output logic              hit
);
    import pcb_pkg::*;

    logic [3:0]        eff_n;
    logic [ADDR_W-1:0] care;
    logic              addr_eq;
    logic              type_ok;
    logic              master_ok;

    // Saturate the mask code to the largest supported ignore width.
    always_comb begin
        if (int'(mask_code) > MASK_MAX) eff_n = 4'(MASK_MAX);
        else                             eff_n = {1'b0, mask_code};
    end

    // One care bit per address bit: compared only at or above the ignore width.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_care
        assign care[g] = (g >= int'(eff_n));
    end

    assign addr_eq   = ((addr ^ bar) & care) == '0;
    assign master_ok = !bus_dma || dma_ok;

    // Decode the condition code against the cycle type.
    always_comb begin
        case (cond_e'(cond))
            COND_FETCH: type_ok = bus_fetch;
            COND_RD:    type_ok = !bus_fetch && !bus_write;
            COND_WR:    type_ok = !bus_fetch && bus_write;
            default:    type_ok = !bus_fetch;
        endcase
    end

    assign hit = bus_valid && addr_eq && master_ok && type_ok;

endmodule

// File: rtl/pcb_channel.sv
// One break channel: break-address bytes, control byte, sticky flag with
// read-as-1-then-write-0 clearing, and its own interrupt output.
// Assumes the register strobes are already qualified for this channel.
module pcb_channel #(
    parameter int ADDR_W   = 24,
    parameter int NBYTES   = ADDR_W / 8,
    parameter int SLOT_W   = 2,
    parameter int MASK_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              sel_wr,
    input  logic              sel_rd,
    input  logic [SLOT_W-1:0] slot,
    input  logic [7:0]        wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_dma,
    input  logic              bus_fetch,
    input  logic              bus_write,
    output logic [7:0]        rdata,
    output logic              hit,
    output logic              flag,
    output logic              irq,
    output logic [7:0]        ctrl_o
);
    import pcb_pkg::*;

    localparam logic [SLOT_W-1:0] CTRL_SLOT = SLOT_W'(NBYTES);

    logic [NBYTES-1:0][7:0] bar_q;
    ctrl_t                  ctrl_q;
    logic                   arm_q;
    logic                   ctrl_wr;
    logic                   ctrl_rd;
    logic                   flag_clr;
    logic                   flag_d;

    assign ctrl_wr = sel_wr && (slot == CTRL_SLOT);
    assign ctrl_rd = sel_rd && (slot == CTRL_SLOT);

    // Break-address bytes, one writable slot each; kept through standby.
    for (genvar b = 0; b < NBYTES; b++) begin : g_bar
        always_ff @(posedge clk) begin
            if (!rst_n)                                bar_q[b] <= '0;
            else if (sel_wr && slot == SLOT_W'(b))     bar_q[b] <= wdata;
        end
    end

    pcb_addr_cmp #(
        .ADDR_W   (ADDR_W),
        .MASK_MAX (MASK_MAX)
    ) u_cmp (
        .bar       (bar_q),
        .addr      (bus_addr),
        .mask_code (ctrl_q.mask),
        .cond      (ctrl_q.cond),
        .dma_ok    (ctrl_q.dma_ok),
        .bus_valid (bus_valid),
        .bus_dma   (bus_dma),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .hit       (hit)
    );

    // A clear needs an armed read and a 0 in bit 7; a new hit wins over it.
    assign flag_clr = ctrl_wr && !wdata[7] && arm_q;
    assign flag_d   = hit || (ctrl_q.flag && !flag_clr);

    // Control byte: software fields from writes, flag from the set/clear rule.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.dma_ok <= wdata[6];
                ctrl_q.mask   <= wdata[5:3];
                ctrl_q.cond   <= wdata[2:1];
                ctrl_q.ie     <= wdata[0];
            end
            ctrl_q.flag <= flag_d;
        end
    end

    // Arm state: set by a read that returns the flag as 1, used up by any write.
    always_ff @(posedge clk) begin
        if (!rst_n || standby)           arm_q <= 1'b0;
        else if (ctrl_wr)                arm_q <= 1'b0;
        else if (ctrl_rd && ctrl_q.flag) arm_q <= 1'b1;
    end

    // Read mux over the address bytes and the control byte.
    always_comb begin
        rdata = '0;
        if (slot == CTRL_SLOT) rdata = ctrl_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (slot == SLOT_W'(b)) rdata = bar_q[b];
        end
    end

    assign flag   = ctrl_q.flag;
    assign irq    = ctrl_q.flag && ctrl_q.ie;
    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/pc_break_unit.sv
// Top of the break comparator: decodes the register port onto the channels
// and merges their interrupt outputs into one request line.
// Assumes reg_addr is {channel index, slot index}.
module pc_break_unit #(
    parameter int ADDR_W   = 24,
    parameter int NUM_CH   = 2,
    parameter int MASK_MAX = 4,
    localparam int NBYTES  = ADDR_W / 8,
    localparam int SLOT_W  = $clog2(NBYTES + 1),
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int REG_AW  = CH_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_dma,
    input  logic              bus_fetch,
    input  logic              bus_write,
    output logic              irq
);
    logic [CH_W-1:0]             ch_idx;
    logic [SLOT_W-1:0]           slot;
    logic [NUM_CH-1:0][7:0]      rdata_v;
    logic [NUM_CH-1:0][7:0]      ctrl_vec;
    logic [NUM_CH-1:0]           hit_vec;
    logic [NUM_CH-1:0]           flag_vec;
    logic [NUM_CH-1:0]           irq_vec;

    assign ch_idx = reg_addr[REG_AW-1:SLOT_W];
    assign slot   = reg_addr[SLOT_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pcb_channel #(
            .ADDR_W   (ADDR_W),
            .NBYTES   (NBYTES),
            .SLOT_W   (SLOT_W),
            .MASK_MAX (MASK_MAX)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .standby   (standby),
            .sel_wr    (reg_wr && ch_idx == CH_W'(c)),
            .sel_rd    (reg_rd && ch_idx == CH_W'(c)),
            .slot      (slot),
            .wdata     (reg_wdata),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_dma   (bus_dma),
            .bus_fetch (bus_fetch),
            .bus_write (bus_write),
            .rdata     (rdata_v[c]),
            .hit       (hit_vec[c]),
            .flag      (flag_vec[c]),
            .irq       (irq_vec[c]),
            .ctrl_o    (ctrl_vec[c])
        );
    end

    // Read data from the addressed channel.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_W'(c)) reg_rdata = rdata_v[c];
        end
    end

    assign irq = |irq_vec;

endmodule

// File: rtl/pcb_checker.sv
// Property checker for pc_break_unit, attached by bind below.
// Assumes reg_addr layout {channel, slot} with the control byte at CTRL_SLOT.
module pcb_checker #(
    parameter int NUM_CH    = 2,
    parameter int SLOT_W    = 2,
    parameter int REG_AW    = 3,
    parameter int CTRL_SLOT = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   standby,
    input logic                   reg_wr,
    input logic [REG_AW-1:0]      reg_addr,
    input logic [7:0]             reg_wdata,
    input logic                   irq,
    input logic [NUM_CH-1:0]      hit_vec,
    input logic [NUM_CH-1:0]      flag_vec,
    input logic [NUM_CH-1:0][7:0] ctrl_vec
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [REG_AW-1:0] CA = REG_AW'(c * (1 << SLOT_W) + CTRL_SLOT);

        // R7: a hit outside standby leaves the flag set after the edge
        p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_vec[c] && !standby) |=> flag_vec[c]);

        // R8: the flag only falls after a 0 written to it, or a standby
        p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_vec[c]) |->
                ($past(standby) || $past(reg_wr && reg_addr == CA && !reg_wdata[7])));
    end

    // R11: standby empties every control byte
    p_standby_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ctrl_vec == '0));

    // R10: a request needs at least one flag
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_vec != '0));

endmodule

bind pc_break_unit pcb_checker #(
    .NUM_CH    (NUM_CH),
    .SLOT_W    (SLOT_W),
    .REG_AW    (REG_AW),
    .CTRL_SLOT (NBYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .hit_vec   (hit_vec),
    .flag_vec  (flag_vec),
    .ctrl_vec  (ctrl_vec)
);

// File: tb/pc_break_unit_tb_top.sv
// Self-checking bench: directed corners plus seeded random match trials.
module pc_break_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_dma = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_write = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [23:0] bar_m [2];

    always #4 clk = ~clk;

    pc_break_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_dma   (bus_dma),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Each task starts just after a falling edge and ends at the next one.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus(input logic [23:0] a, input logic dma, input logic f, input logic w);
        bus_addr = a; bus_dma = dma; bus_fetch = f; bus_write = w; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_bar(input int ch, input logic [23:0] v);
        wr(3'(ch * 4 + 0), v[7:0]);
        wr(3'(ch * 4 + 1), v[15:8]);
        wr(3'(ch * 4 + 2), v[23:16]);
        bar_m[ch] = v;
    endtask

    // Expected match from the requirement text (R3..R6).
    function automatic logic exp_hit(input logic [23:0] bar, input logic [6:0] c,
                                     input logic [23:0] a, input logic dma,
                                     input logic f, input logic w);
        int n;
        logic [23:0] care;
        logic ty;
        n = (int'(c[5:3]) > 4) ? 4 : int'(c[5:3]);
        care = ~((24'd1 << n) - 24'd1);
        case (c[2:1])
            2'b00:   ty = f;
            2'b01:   ty = !f && !w;
            2'b10:   ty = !f && w;
            default: ty = !f;
        endcase
        return (((a ^ bar) & care) == 24'd0) && (!dma || c[6]) && ty;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic [6:0] c7;
        logic [23:0] a;
        logic dm, f, w, e;
        int ch;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd3, d); check("R1 ctrl A", d, 8'h00);
        rd(3'd7, d); check("R1 ctrl B", d, 8'h00);
        check("R1 irq", irq, 0);

        // R2: address bytes read back per slot
        set_bar(0, 24'h123456);
        set_bar(1, 24'hABCDEF);
        rd(3'd0, d); check("R2 A byte0", d, 8'h56);
        rd(3'd1, d); check("R2 A byte1", d, 8'h34);
        rd(3'd2, d); check("R2 A byte2", d, 8'h12);
        rd(3'd6, d); check("R2 B byte2", d, 8'hAB);
        rd(3'd4, d); check("R2 B byte0", d, 8'hEF);

        // R3: exact compare, data read, CPU only
        wr(3'd3, 8'h02);
        bus(24'h123457, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d); check("R3 off-by-one miss", d, 8'h02);
        bus(24'h123456, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d); check("R3 exact hit", d, 8'h82);
        // R7: sticky through a non-matching cycle
        bus(24'h000000, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d); check("R7 sticky", d, 8'h82);
        wr(3'd3, 8'h02);
        rd(3'd3, d); check("R8 armed clear", d, 8'h02);

        // R4: code 7 behaves like 4
        wr(3'd3, 8'h3A);
        bus(24'h123446, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d); check("R4 bit4 differs miss", d, 8'h3A);
        bus(24'h12345F, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d); check("R4 low nibble ignored", d, 8'hBA);
        wr(3'd3, 8'h3A);

        // R5: bus master qualification
        wr(3'd3, 8'h02);
        bus(24'h123456, 1'b1, 1'b0, 1'b0);
        rd(3'd3, d); check("R5 dma blocked", d, 8'h02);
        wr(3'd3, 8'h42);
        bus(24'h123456, 1'b1, 1'b0, 1'b0);
        rd(3'd3, d); check("R5 dma allowed", d, 8'hC2);
        wr(3'd3, 8'h42);

        // R6: fetch condition ignores a data read, takes a fetch
        wr(3'd3, 8'h00);
        bus(24'h123456, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d); check("R6 fetch vs read", d, 8'h00);
        bus(24'h123456, 1'b0, 1'b1, 1'b0);
        rd(3'd3, d); check("R6 fetch hit", d, 8'h80);
        wr(3'd3, 8'h00);

        // R8: write 0 without a prior read does not clear
        wr(3'd3, 8'h02);
        bus(24'h123456, 1'b0, 1'b0, 1'b0);
        wr(3'd3, 8'h02);
        rd(3'd3, d); check("R8 unarmed write0", d, 8'h82);
        wr(3'd3, 8'h82);
        wr(3'd3, 8'h02);
        rd(3'd3, d); check("R8 write1 then write0", d, 8'h82);
        wr(3'd3, 8'h02);
        rd(3'd3, d); check("R8 clear after read", d, 8'h02);

        // R9: clear and new match in the same cycle
        bus(24'h123456, 1'b0, 1'b0, 1'b0);
        rd(3'd3, d);
        reg_addr = 3'd3; reg_wdata = 8'h02; reg_wr = 1'b1;
        bus_addr = 24'h123456; bus_dma = 1'b0; bus_fetch = 1'b0; bus_write = 1'b0;
        bus_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; bus_valid = 1'b0;
        rd(3'd3, d); check("R9 match beats clear", d, 8'h82);
        wr(3'd3, 8'h02);

        // R10: interrupt merge
        bus(24'h123456, 1'b0, 1'b0, 1'b0);
        check("R10 flag without enable", irq, 0);
        wr(3'd3, 8'h83);
        check("R10 A enabled", irq, 1);
        wr(3'd7, 8'h07);
        bus(24'hABCDEF, 1'b0, 1'b0, 1'b1);
        rd(3'd3, d);
        wr(3'd3, 8'h03);
        rd(3'd3, d); check("R10 A cleared", d, 8'h03);
        check("R10 B keeps irq", irq, 1);
        rd(3'd7, d);
        wr(3'd7, 8'h07);
        check("R10 both clear", irq, 0);

        // R11: standby clears control, keeps addresses
        bus(24'h123456, 1'b0, 1'b0, 1'b0);
        bus(24'hABCDEF, 1'b0, 1'b0, 1'b1);
        check("R11 pre irq", irq, 1);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        rd(3'd3, d); check("R11 ctrl A", d, 8'h00);
        rd(3'd7, d); check("R11 ctrl B", d, 8'h00);
        check("R11 irq", irq, 0);
        rd(3'd1, d); check("R11 A addr kept", d, 8'h34);
        rd(3'd5, d); check("R11 B addr kept", d, 8'hCD);

        // R7 with R4 R5 R6: random trials
        for (int i = 0; i < 400; i++) begin
            ch = int'($urandom % 2);
            c7 = 7'($urandom);
            if ($urandom % 8 == 0) set_bar(ch, 24'($urandom));
            wr(3'(ch * 4 + 3), {1'b0, c7});
            if ($urandom % 2 == 0) a = bar_m[ch] ^ 24'($urandom % 32);
            else                   a = 24'($urandom);
            dm = 1'($urandom); f = 1'($urandom); w = 1'($urandom);
            e = exp_hit(bar_m[ch], c7, a, dm, f, w);
            bus(a, dm, f, w);
            rd(3'(ch * 4 + 3), d);
            check("R7 random flag", d, {e, c7});
            check("R10 random irq", irq, e && c7[0]);
            if (e) wr(3'(ch * 4 + 3), {1'b0, c7});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule